// File: doc/BRIEF.md
# Periodic Interrupt Pulse Generator

This block produces the periodic maskable interrupt request for an 8-bit main processor. A divider turns the fast input clock into a one-in-four count enable (the E-cycle tick). A counter holds the interrupt low for an interval picked by two jumper inputs, then raises it for a fixed 32-tick pulse, and repeats.

While the pulse is up, a handshake line is pulled low and two diagnostic buttons pass through to their outputs. Outside the pulse, both button outputs sit high. When any peripheral interrupt request is active, the periodic counter is held at zero and the interrupt is reported active. Once the request drops, the interrupt clears and a full interval starts again.

A separate button is synchronised and edge detected. Its release yields a one-clock non-maskable interrupt pulse.

Top module: `irq_pulse_gen`

## Requirements
- R1: The count enable fires once every 4 input clocks (DIV), so every interval and pulse length below is four input clocks per tick.
- R2: The low interval in ticks is decoded from `jumper_i`: 2'b00 gives 768, 2'b01 gives 896, 2'b10 gives 1792 and 2'b11 gives 1920. With no peripheral request, `irq_o` stays low for exactly 4 times that many input clocks after reset and after each pulse.
- R3: Once the interval ends, `irq_o` is high for exactly 32 ticks (128 input clocks).
- R4: `handshake_o` is low exactly while the timed pulse is high, and high at all other times, including during a peripheral hold.
- R5: While the timed pulse is high, `diag_adv_o` and `diag_ud_o` equal `btn_adv_i` and `btn_ud_i` in the same cycle. At all other times both are 1.
- R6: One clock after any bit of `periph_irq_i` is 1, `irq_o` is 1, `handshake_o` is 1 and both diagnostic outputs are 1. This holds whether the request arrives in the interval or in the pulse, and the counter is held at zero.
- R7: One clock after `periph_irq_i` returns to all zeros, `irq_o` is 0. A full interval then restarts, so the next rise comes after between 4*I-3 and 4*I input clocks, depending on the divider phase.
- R8: Releasing `btn_nmi_i` (1 to 0) raises `nmi_o` for exactly one clock, two clocks after the release is sampled. Pressing the button produces no pulse.
- R9: During and right after reset, `irq_o`=0, `handshake_o`=1, both diagnostic outputs are 1 and `nmi_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jumper_i | input | 2 | Interval select |
| periph_irq_i | input | NUM_REQ (4) | Peripheral interrupt requests, active high |
| btn_adv_i | input | 1 | Advance diagnostic button level |
| btn_ud_i | input | 1 | Up/down diagnostic button level |
| btn_nmi_i | input | 1 | NMI button, 1 while pressed |
| irq_o | output | 1 | Maskable interrupt, active high |
| handshake_o | output | 1 | Low during the timed pulse |
| diag_adv_o | output | 1 | Gated advance button |
| diag_ud_o | output | 1 | Gated up/down button |
| nmi_o | output | 1 | One-clock NMI pulse |

## Verification
The interrupt edges are registered, so the bench measures run lengths of `irq_o` in whole input clocks at falling edges. It compares each low run with 4*I and each high run with 128. A run after a peripheral release is compared with a window, because the free-running divider phase is not reset by the hold.

The hold response and the release response are each due one clock after the request changes, so they are sampled at the next falling edge. The gated button outputs are combinational, so they are checked just after inputs are driven in the same cycle. The NMI pulse is expected exactly at the second falling edge after release, with a low sample on each side.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    PH_COUNT = 2'd0,
    PH_PULSE = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    div_q <= '0;
    else if (div_q == DW'(DIV - 1)) div_q <= '0;
    else                            div_q <= div_q + DW'(1);
  end

  assign tick_o = (div_q == DW'(DIV - 1));

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ival_decode.sv
module ival_decode #(
  parameter int CNT_W  = 11,
  parameter int IVAL_0 = 'h300,
  parameter int IVAL_1 = 'h380,
  parameter int IVAL_2 = 'h700,
  parameter int IVAL_3 = 'h780
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] ival_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   ival_o = CNT_W'(IVAL_0);
      2'b01:   ival_o = CNT_W'(IVAL_1);
      2'b10:   ival_o = CNT_W'(IVAL_2);
      default: ival_o = CNT_W'(IVAL_3);
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import irq_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int PULSE_LEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] ival_i,
  output phase_e           phase_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_COUNT;
      cnt_q   <= '0;
    end else if (hold_i) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          phase_q <= PH_COUNT;
          cnt_q   <= '0;
        end
        PH_COUNT: if (tick_i) begin
          // >= so a jumper change mid-interval cannot skip the end
          if (cnt_q >= ival_i - CNT_W'(1)) begin
            phase_q <= PH_PULSE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_PULSE: if (tick_i) begin
          if (cnt_q == CNT_W'(PULSE_LEN - 1)) begin
            phase_q <= PH_COUNT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          phase_q <= PH_COUNT;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PULSE) |-> (cnt_q < CNT_W'(PULSE_LEN)));

  // R6
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0 && phase_q == PH_HOLD));
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic nmi_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], btn_i};
  end

  // release = falling edge after synchronisation
  assign nmi_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

  // R8
  nmi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int NUM_REQ   = 4,
  parameter int PULSE_LEN = 32,
  parameter int IVAL_0    = 'h300,
  parameter int IVAL_1    = 'h380,
  parameter int IVAL_2    = 'h700,
  parameter int IVAL_3    = 'h780
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         jumper_i,
  input  logic [NUM_REQ-1:0] periph_irq_i,
  input  logic               btn_adv_i,
  input  logic               btn_ud_i,
  input  logic               btn_nmi_i,
  output logic               irq_o,
  output logic               handshake_o,
  output logic               diag_adv_o,
  output logic               diag_ud_o,
  output logic               nmi_o
);
  localparam int MAX_A    = (IVAL_0 > IVAL_1) ? IVAL_0 : IVAL_1;
  localparam int MAX_B    = (IVAL_2 > IVAL_3) ? IVAL_2 : IVAL_3;
  localparam int MAX_I    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL  = (MAX_I > PULSE_LEN) ? MAX_I : PULSE_LEN;
  localparam int CNT_W    = $clog2(MAX_ALL + 1);

  logic             tick;
  logic             hold;
  logic [CNT_W-1:0] ival;
  phase_e           phase;
  logic             in_pulse;

  assign hold = |periph_irq_i;

  tick_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ival_decode #(
    .CNT_W(CNT_W), .IVAL_0(IVAL_0), .IVAL_1(IVAL_1),
    .IVAL_2(IVAL_2), .IVAL_3(IVAL_3)
  ) u_dec (
    .sel_i  (jumper_i),
    .ival_o (ival)
  );

  interval_timer #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .hold_i  (hold),
    .ival_i  (ival),
    .phase_o (phase)
  );

  nmi_edge #(.SYNC_STAGES(2)) u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_nmi_i),
    .nmi_o  (nmi_o)
  );

  assign in_pulse    = (phase == PH_PULSE);
  assign irq_o       = (phase != PH_COUNT);
  assign handshake_o = ~in_pulse;
  assign diag_adv_o  = in_pulse ? btn_adv_i : 1'b1;
  assign diag_ud_o   = in_pulse ? btn_ud_i  : 1'b1;

  // R4
  hshake_in_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !handshake_o |-> irq_o);

  // R5
  diag_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (diag_adv_o && diag_ud_o));

  // R6
  hold_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (irq_o && handshake_o));

  // R7
  release_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold) |=> !irq_o);
endmodule

// File: tb/irq_pulse_gen_tb_top.sv
module irq_pulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REQ    = 4;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [1:0]         jumper_i = 2'b01;
  logic [NUM_REQ-1:0] periph_irq_i = '0;
  logic               btn_adv_i = 1'b1;
  logic               btn_ud_i = 1'b1;
  logic               btn_nmi_i = 1'b0;
  logic               irq_o, handshake_o, diag_adv_o, diag_ud_o, nmi_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pulse_gen #(.NUM_REQ(NUM_REQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .jumper_i(jumper_i),
    .periph_irq_i(periph_irq_i), .btn_adv_i(btn_adv_i), .btn_ud_i(btn_ud_i),
    .btn_nmi_i(btn_nmi_i), .irq_o(irq_o), .handshake_o(handshake_o),
    .diag_adv_o(diag_adv_o), .diag_ud_o(diag_ud_o), .nmi_o(nmi_o)
  );

  function automatic int exp_ival(input logic [1:0] j);
    case (j)
      2'b00:   return 768;
      2'b01:   return 896;
      2'b10:   return 1792;
      default: return 1920;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (irq_o === v && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [1:0] j);
    @(negedge clk);
    rst_ni = 1'b0;
    jumper_i = j;
    periph_irq_i = '0;
    btn_nmi_i = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    check(irq_o === 1'b0 && handshake_o === 1'b1 && diag_adv_o === 1'b1 &&
          diag_ud_o === 1'b1 && nmi_o === 1'b0, "R9 reset state",
          {irq_o, handshake_o, diag_adv_o, diag_ud_o, nmi_o}, 5'b01110);
    rst_ni = 1'b1;
  endtask

  initial begin
    int n, iv, w;
    logic a, u;
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);

    // timed sequence for every jumper setting
    for (int j = 0; j < 4; j++) begin
      do_reset(2'(j));
      iv = exp_ival(2'(j));
      run_len(1'b0, n);
      // R1 R2
      check(n == 4*iv, "R2 first low run", n, 4*iv);
      a = 1'($urandom); u = 1'($urandom);
      btn_adv_i = a; btn_ud_i = u;
      #1;
      // R5
      check(diag_adv_o === a && diag_ud_o === u, "R5 pass-through", {diag_adv_o, diag_ud_o}, {a, u});
      // R4
      check(handshake_o === 1'b0, "R4 low in pulse", handshake_o, 0);
      run_len(1'b1, n);
      // R3
      check(n == 128, "R3 pulse length", n, 128);
      btn_adv_i = 1'b0; btn_ud_i = 1'b0;
      #1;
      check(diag_adv_o === 1'b1 && diag_ud_o === 1'b1, "R5 forced high", {diag_adv_o, diag_ud_o}, 3);
      check(handshake_o === 1'b1, "R4 high outside pulse", handshake_o, 1);
      run_len(1'b0, n);
      check(n == 4*iv, "R1 R2 steady low run", n, 4*iv);
    end

    // peripheral hold during interval
    for (int k = 0; k < 3; k++) begin
      do_reset(2'($urandom));
      iv = exp_ival(jumper_i);
      w = 10 + int'($urandom % 500);
      repeat (w) @(negedge clk);
      btn_adv_i = 1'b0; btn_ud_i = 1'b0;
      periph_irq_i = NUM_REQ'(1) << ($urandom % NUM_REQ);
      @(negedge clk);
      // R6
      check(irq_o === 1'b1 && handshake_o === 1'b1 && diag_adv_o === 1'b1 && diag_ud_o === 1'b1,
            "R6 hold response", {irq_o, handshake_o, diag_adv_o, diag_ud_o}, 4'b1111);
      w = 1 + int'($urandom % 300);
      repeat (w) @(negedge clk);
      check(irq_o === 1'b1, "R6 hold persists", irq_o, 1);
      periph_irq_i = '0;
      @(negedge clk);
      // R7
      check(irq_o === 1'b0, "R7 release clears irq", irq_o, 0);
      run_len(1'b0, n);
      check(n >= 4*iv-3 && n <= 4*iv, "R7 interval restart", n, 4*iv);
    end

    // peripheral hold arriving inside the pulse
    do_reset(2'b00);
    run_len(1'b0, n);
    repeat (5) @(negedge clk);
    check(handshake_o === 1'b0, "R4 pulse before hold", handshake_o, 0);
    periph_irq_i = 4'b1000;
    @(negedge clk);
    check(irq_o === 1'b1 && handshake_o === 1'b1, "R6 hold in pulse", {irq_o, handshake_o}, 3);
    periph_irq_i = '0;
    @(negedge clk);
    check(irq_o === 1'b0, "R7 release after pulse hold", irq_o, 0);

    // NMI button
    btn_nmi_i = 1'b1;
    n = 0;
    repeat (6) begin
      @(negedge clk);
      if (nmi_o !== 1'b0) n++;
    end
    // R8
    check(n == 0, "R8 no pulse on press", n, 0);
    btn_nmi_i = 1'b0;
    @(negedge clk);
    check(nmi_o === 1'b0, "R8 latency first clock", nmi_o, 0);
    @(negedge clk);
    check(nmi_o === 1'b1, "R8 pulse on release", nmi_o, 1);
    @(negedge clk);
    check(nmi_o === 1'b0, "R8 pulse one clock", nmi_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule